// File: doc/BRIEF.md
# Direct-Mapped Store-Through Data Cache

This block is a data cache placed between a processor port and a memory port. Both ports carry 32-bit addresses and 32-bit data. The cache holds one 32-bit word per line and is direct mapped. Each line keeps a valid flag, a tag and a data word. A load that finds its word in the cache returns it in the same cycle. A load that misses reads the word from memory, installs it, and then completes.

Every store is sent on to memory. Stores enter a small first-in first-out queue, and the queue writes to memory in the background while the processor keeps running. The processor waits on a store only when that queue is full. A store whose line is present also updates the cached word. A store whose line is absent leaves the cache unchanged. A load miss holds its memory read until the queue is empty. Memory therefore always holds every earlier store before the read, including a store to the same word.

Top module: `store_through_cache`

## Requirements
- R1: A load whose line is valid and whose stored tag equals address bits [31:12] (the line is picked by bits [11:2]; bits [1:0] are ignored) raises cpuReady in the same cycle it is presented and returns the cached word, with no memory read.
- R2: A load that misses issues exactly one memory read (memReq high, memWe low) at the load address, installs the returned word, and then completes with that word.
- R3: Two addresses with equal bits [11:2] but different bits [31:12] share one line, so loading one evicts the other and the next load of the first misses.
- R4: Every accepted store (cpuReq, cpuWe and cpuReady high at a clock edge) later appears as exactly one memory write (memReq and memWe high, accepted when memReady is high) with the same address and data. A memory request, once raised, stays raised with the same direction until memReady.
- R5: A store to a valid line with a matching tag also updates the cached word, so a later load of that address hits and returns the stored value without reading memory.
- R6: A store that misses does not install a line, so a later load of that address misses.
- R7: With memory stalled, DEPTH stores (DEPTH = 4 by default) are accepted with cpuReady high in their first cycle. A further store sees cpuReady low until an entry has drained to memory.
- R8: Buffered stores reach memory in the order they were accepted.
- R9: A load miss issues no memory read while any store is still buffered. Its read follows the last buffered write.
- R10: Reset clears every valid flag and discards all buffered stores. After reset no discarded store reaches memory, and a load of a previously cached address misses.
- R11: While buffered stores are waiting on memory, a load that hits still completes in its first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cpuReq | input | 1 | Processor request valid, held until cpuReady |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | 32 | Processor byte address, held while waiting |
| cpuWdata | input | 32 | Store data |
| cpuReady | output | 1 | Request accepted at this clock edge |
| cpuRdata | output | 32 | Load data, valid when cpuReady is high for a load |
| memReq | output | 1 | Memory request valid |
| memWe | output | 1 | 1 = memory write, 0 = memory read |
| memAddr | output | 32 | Memory address |
| memWdata | output | 32 | Memory write data |
| memReady | input | 1 | Memory accepts or completes the request at this edge |
| memRdata | input | 32 | Memory read data, valid with memReady |

## Verification
The bench uses the default parameters: a 10-bit index (1024 lines) and a four-entry store queue. With the 10-bit index, addresses such as 0x1004 and 0x3004 fall on the same line, which makes eviction easy to provoke. With four entries, the queue fills after four stores and the fifth one stalls. The bench's memory model can be held off indefinitely. This makes a full queue, draining while loads hit, reads that wait behind writes, and a reset with stores still queued each reachable on demand.

// File: rtl/stc_pkg.sv
package stc_pkg;
  // Strobes from the sequencer to the storage datapath
  typedef struct packed {
    logic fillWr;    // install memory word into the indexed line
    logic storeUpd;  // overwrite cached word on a store hit
    logic bufPush;   // enqueue a store
    logic bufPop;    // head of queue accepted by memory
    logic readSel;   // memory port carries the load-miss read
  } stcStrobes_t;
endpackage

// File: rtl/stc_wbuf.sv
module stc_wbuf #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] pushAddr,
  input  logic [DW-1:0] pushData,
  input  logic          pop,
  output logic [AW-1:0] headAddr,
  output logic [DW-1:0] headData,
  output logic          empty,
  output logic          full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0] addrQ [DEPTH];
  logic [DW-1:0] dataQ [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [PW:0]   count;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) begin
      addrQ[wrPtr] <= pushAddr;
      dataQ[wrPtr] <= pushData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= bump(wrPtr);
      if (pop)  rdPtr <= bump(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign headAddr = addrQ[rdPtr];
  assign headData = dataQ[rdPtr];
  assign empty    = (count == '0);
  assign full     = (count == (PW+1)'(DEPTH));

  // R7
  push_when_full_chk: assert property (@(posedge clk) disable iff (rst) full |-> !push);
  // R8
  pop_when_empty_chk: assert property (@(posedge clk) disable iff (rst) empty |-> !pop);
  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (rst) count <= (PW+1)'(DEPTH));
endmodule

// File: rtl/stc_datapath.sv
module stc_datapath
  import stc_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int IDX_W = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  stcStrobes_t   strb,
  input  logic [AW-3:0] lineAddr,
  input  logic [DW-1:0] cpuWdata,
  input  logic [DW-1:0] memRdata,
  output logic          hit,
  output logic [DW-1:0] rdData
);
  localparam int TAG_W = AW - 2 - IDX_W;
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] validQ;
  logic [TAG_W-1:0] tagMem  [LINES];
  logic [DW-1:0]    dataMem [LINES];

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;

  assign idx = lineAddr[IDX_W-1:0];
  assign tag = lineAddr[AW-3 -: TAG_W];

  always_ff @(posedge clk) begin
    if (rst) validQ <= '0;
    else if (strb.fillWr) validQ[idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strb.fillWr) begin
      tagMem[idx]  <= tag;
      dataMem[idx] <= memRdata;
    end else if (strb.storeUpd) begin
      dataMem[idx] <= cpuWdata;
    end
  end

  assign hit    = validQ[idx] && (tagMem[idx] == tag);
  assign rdData = dataMem[idx];

  // R5
  store_update_hit_chk: assert property (@(posedge clk) disable iff (rst) strb.storeUpd |-> hit);
  // R6
  fill_not_on_store_chk: assert property (@(posedge clk) disable iff (rst) !(strb.fillWr && strb.bufPush));
endmodule

// File: rtl/stc_ctrl.sv
module stc_ctrl
  import stc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cpuReq,
  input  logic        cpuWe,
  input  logic        hit,
  input  logic        bufEmpty,
  input  logic        bufFull,
  input  logic        memReady,
  output logic        cpuReady,
  output logic        memReq,
  output logic        memWe,
  output stcStrobes_t strb
);
  typedef enum logic {ST_IDLE, ST_FILL} ctrlState_t;
  ctrlState_t state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    cpuReady  = 1'b0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    strb      = '0;
    case (state)
      ST_IDLE: begin
        memReq      = !bufEmpty;
        memWe       = !bufEmpty;
        strb.bufPop = !bufEmpty && memReady;
        if (cpuWe) begin
          cpuReady      = !bufFull;
          strb.bufPush  = cpuReq && !bufFull;
          strb.storeUpd = cpuReq && !bufFull && hit;
        end else begin
          cpuReady = hit;
          if (cpuReq && !hit && bufEmpty) nextState = ST_FILL;
        end
      end
      ST_FILL: begin
        memReq       = 1'b1;
        strb.readSel = 1'b1;
        strb.fillWr  = memReady;
        if (memReady) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  // R9
  read_after_drain_chk: assert property (@(posedge clk) disable iff (rst) (memReq && !memWe) |-> bufEmpty);
  // R4
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memReady) |=> (memReq && (memWe == $past(memWe))));
endmodule

// File: rtl/store_through_cache.sv
module store_through_cache
  import stc_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int IDX_W     = 10,
  parameter int BUF_DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpuReq,
  input  logic          cpuWe,
  input  logic [AW-1:0] cpuAddr,
  input  logic [DW-1:0] cpuWdata,
  output logic          cpuReady,
  output logic [DW-1:0] cpuRdata,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  input  logic          memReady,
  input  logic [DW-1:0] memRdata
);
  stcStrobes_t   strb;
  logic          hit, bufEmpty, bufFull;
  logic [AW-1:0] headAddr;

  stc_ctrl i_ctrl (
    .clk(clk), .rst(rst), .cpuReq(cpuReq), .cpuWe(cpuWe), .hit(hit),
    .bufEmpty(bufEmpty), .bufFull(bufFull), .memReady(memReady),
    .cpuReady(cpuReady), .memReq(memReq), .memWe(memWe), .strb(strb)
  );

  stc_datapath #(.AW(AW), .DW(DW), .IDX_W(IDX_W)) i_datapath (
    .clk(clk), .rst(rst), .strb(strb), .lineAddr(cpuAddr[AW-1:2]),
    .cpuWdata(cpuWdata), .memRdata(memRdata), .hit(hit), .rdData(cpuRdata)
  );

  stc_wbuf #(.AW(AW), .DW(DW), .DEPTH(BUF_DEPTH)) i_wbuf (
    .clk(clk), .rst(rst), .push(strb.bufPush), .pushAddr(cpuAddr),
    .pushData(cpuWdata), .pop(strb.bufPop), .headAddr(headAddr),
    .headData(memWdata), .empty(bufEmpty), .full(bufFull)
  );

  assign memAddr = strb.readSel ? cpuAddr : headAddr;
endmodule

// File: tb/test_store_through_cache.sv
`timescale 1ns/1ps
module test_store_through_cache;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpuReq = 1'b0, cpuWe = 1'b0;
  logic [31:0] cpuAddr = '0, cpuWdata = '0;
  logic        cpuReady;
  logic [31:0] cpuRdata;
  logic        memReq, memWe;
  logic [31:0] memAddr, memWdata;
  logic        memReady;
  logic [31:0] memRdata;

  int checks = 0, fails = 0;
  logic memHold = 1'b0;
  int memLat = 2;
  int waitCnt = 0;
  int readCnt = 0, writeCnt = 0, logCnt = 0;
  logic [31:0] logAddr [64];
  logic [31:0] logData [64];
  logic        logWe   [64];
  logic [31:0] memModel [logic [31:0]];
  logic [31:0] refMem   [logic [31:0]];

  always #4 clk = ~clk;

  store_through_cache i_store_through_cache (
    .clk(clk), .rst(rst), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuReady(cpuReady), .cpuRdata(cpuRdata),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memReady(memReady), .memRdata(memRdata)
  );

  function automatic logic [31:0] defVal(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h0F0F_0000;
  endfunction

  function automatic logic [31:0] modelRead(input logic [31:0] a);
    if (memModel.exists(a)) return memModel[a];
    return defVal(a);
  endfunction

  function automatic logic [31:0] expRead(input logic [31:0] a);
    if (refMem.exists(a)) return refMem[a];
    return defVal(a);
  endfunction

  // Memory responder with programmable latency and a hold switch
  always @(posedge clk) begin
    if (rst) begin
      memReady <= 1'b0;
      memRdata <= '0;
      waitCnt = 0;
    end else if (memReady) begin
      if (memReq) begin
        if (memWe) begin
          memModel[memAddr] = memWdata;
          writeCnt++;
        end else begin
          readCnt++;
        end
        if (logCnt < 64) begin
          logAddr[logCnt] = memAddr;
          logData[logCnt] = memWdata;
          logWe[logCnt]   = memWe;
        end
        logCnt++;
      end
      memReady <= 1'b0;
      waitCnt = 0;
    end else if (memReq && !memHold) begin
      if (waitCnt >= memLat) begin
        memReady <= 1'b1;
        memRdata <= modelRead(memAddr);
      end else begin
        waitCnt++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic doStore(input logic [31:0] a, input logic [31:0] d, output int waited);
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = 1'b1; cpuAddr = a; cpuWdata = d;
    waited = 0;
    #1;
    while (!cpuReady && waited < 500) begin
      @(negedge clk); #1; waited++;
    end
    @(posedge clk); #1;
    cpuReq = 1'b0;
    refMem[a] = d;
  endtask

  task automatic doLoad(input logic [31:0] a, output logic [31:0] d, output int waited);
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = 1'b0; cpuAddr = a;
    waited = 0;
    #1;
    while (!cpuReady && waited < 500) begin
      @(negedge clk); #1; waited++;
    end
    d = cpuRdata;
    @(posedge clk); #1;
    cpuReq = 1'b0;
  endtask

  task automatic waitDrain();
    int n = 0;
    @(negedge clk); #1;
    while (memReq && n < 500) begin
      @(negedge clk); #1; n++;
    end
  endtask

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] data;
    logic        expHit;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 32'h0000_1004, 32'h0000_0000, 1'b0},  // cold miss
    '{1'b0, 32'h0000_1004, 32'h0000_0000, 1'b1},  // now cached
    '{1'b1, 32'h0000_1004, 32'h1111_1111, 1'b1},  // store hit
    '{1'b0, 32'h0000_1004, 32'h0000_0000, 1'b1},  // sees new word, no read
    '{1'b1, 32'h0000_2008, 32'h2222_2222, 1'b0},  // store miss, no install
    '{1'b0, 32'h0000_2008, 32'h0000_0000, 1'b0},  // misses, reads drained value
    '{1'b0, 32'h0000_3004, 32'h0000_0000, 1'b0},  // same line, other tag
    '{1'b0, 32'h0000_1004, 32'h0000_0000, 1'b0},  // evicted; memory has store
    '{1'b0, 32'hFFFF_FFFC, 32'h0000_0000, 1'b0},
    '{1'b0, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1}   // offset bits ignored
  };
  string vecReq [NVEC];

  task automatic runTests();
    int w, r0, l0;
    logic [31:0] d;
    bit ok;
    vecReq = '{"R2", "R1", "R4", "R5", "R4", "R6", "R3", "R4", "R2", "R1"};

    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk); #1;
    check(!memReq, "R10", "memReq idle after reset", {31'b0, memReq}, 32'h0);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      r0 = readCnt;
      if (VECS[i].we) begin
        doStore(VECS[i].addr, VECS[i].data, w);
        check(w == 0, vecReq[i], $sformatf("vec %0d store accepted at once", i), w, 0);
      end else begin
        doLoad(VECS[i].addr, d, w);
        check(d == expRead({VECS[i].addr[31:2], 2'b00}), vecReq[i],
              $sformatf("vec %0d load data", i), d, expRead({VECS[i].addr[31:2], 2'b00}));
        check((w == 0) == VECS[i].expHit, vecReq[i], $sformatf("vec %0d hit/miss", i),
              {31'b0, w == 0}, {31'b0, VECS[i].expHit});
        check((readCnt - r0) == (VECS[i].expHit ? 0 : 1), vecReq[i],
              $sformatf("vec %0d memory reads", i), readCnt - r0, VECS[i].expHit ? 0 : 1);
      end
    end
    waitDrain();
    check(memModel.exists(32'h0000_2008) && memModel[32'h0000_2008] == 32'h2222_2222, "R4",
          "store miss written to memory", modelRead(32'h0000_2008), 32'h2222_2222);

    // R7 / R8: fill queue against a stalled memory
    memHold = 1'b1;
    l0 = logCnt;
    ok = 1'b1;
    for (int i = 0; i < 4; i++) begin
      doStore(32'h7000_0000 + 32'(i * 4), 32'hA000_0000 + 32'(i), w);
      if (w != 0) ok = 1'b0;
    end
    check(ok, "R7", "four stores absorbed without stall", {31'b0, ok}, 32'h1);
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = 1'b1; cpuAddr = 32'h7000_0010; cpuWdata = 32'hA000_0004;
    #1;
    ok = 1'b1;
    for (int k = 0; k < 5; k++) begin
      if (cpuReady) ok = 1'b0;
      @(negedge clk); #1;
    end
    check(ok, "R7", "fifth store held off while full", {31'b0, ok}, 32'h1);
    memHold = 1'b0;
    w = 0;
    while (!cpuReady && w < 500) begin
      @(negedge clk); #1; w++;
    end
    check(cpuReady, "R7", "fifth store accepted after drain", {31'b0, cpuReady}, 32'h1);
    @(posedge clk); #1;
    cpuReq = 1'b0;
    refMem[32'h7000_0010] = 32'hA000_0004;
    waitDrain();
    ok = 1'b1;
    for (int i = 0; i < 5; i++) begin
      if (!logWe[l0 + i] || logAddr[l0 + i] != 32'h7000_0000 + 32'(i * 4) ||
          logData[l0 + i] != 32'hA000_0000 + 32'(i)) ok = 1'b0;
    end
    check(ok && (logCnt - l0 == 5), "R8", "writes reach memory in issue order",
          logCnt - l0, 5);

    // R9: load miss waits behind a buffered write
    memHold = 1'b1;
    doStore(32'h4000_0010, 32'h4444_4444, w);
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = 1'b0; cpuAddr = 32'h5000_0020;
    #1;
    ok = 1'b1;
    for (int k = 0; k < 4; k++) begin
      if ((memReq && !memWe) || cpuReady) ok = 1'b0;
      @(negedge clk); #1;
    end
    check(ok, "R9", "no read while store buffered", {31'b0, ok}, 32'h1);
    l0 = logCnt;
    memHold = 1'b0;
    w = 0;
    while (!cpuReady && w < 500) begin
      @(negedge clk); #1; w++;
    end
    d = cpuRdata;
    @(posedge clk); #1;
    cpuReq = 1'b0;
    check(d == expRead(32'h5000_0020), "R9", "miss data after drain", d, expRead(32'h5000_0020));
    check(logCnt - l0 == 2 && logWe[l0] && logAddr[l0] == 32'h4000_0010 && !logWe[l0 + 1] &&
          logAddr[l0 + 1] == 32'h5000_0020, "R9", "write precedes read", logCnt - l0, 2);

    // R11: hit served while queue waits on memory
    memHold = 1'b1;
    doStore(32'h6000_0000, 32'h6666_6666, w);
    doLoad(32'hFFFF_FFFC, d, w);
    check(w == 0 && d == expRead(32'hFFFF_FFFC), "R11", "hit during pending write",
          d, expRead(32'hFFFF_FFFC));
    check(memReq && memWe, "R11", "write still pending", {31'b0, memReq}, 32'h1);
    memHold = 1'b0;
    waitDrain();

    // R10: reset discards queued stores and invalidates lines
    memHold = 1'b1;
    doStore(32'h8000_0000, 32'h8888_8888, w);
    doStore(32'h8000_0004, 32'h9999_9999, w);
    refMem.delete(32'h8000_0000);
    refMem.delete(32'h8000_0004);
    w = writeCnt;
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    memHold = 1'b0;
    repeat (20) @(negedge clk);
    check(writeCnt == w, "R10", "queued stores dropped by reset", writeCnt, w);
    r0 = readCnt;
    doLoad(32'hFFFF_FFFC, d, w);
    check(w != 0 && readCnt - r0 == 1, "R10", "line invalid after reset", readCnt - r0, 1);
    check(d == expRead(32'hFFFF_FFFC), "R10", "refill data after reset", d, expRead(32'hFFFF_FFFC));
  endtask

  initial begin
    fork
      runTests();
      begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule